// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block takes frames that a receive filter has already accepted and lays them into a circular buffer held in local byte memory. The buffer is divided into 256-byte pages. Its extent is given by a first page and a limit page (one past the last usable page). A boundary page marks where the host has stopped reading. A current page marks where the next frame goes. Each stored frame begins on a page boundary. A four-byte descriptor sits ahead of the frame data and tells the host the frame status, where the following frame starts and how many bytes this entry holds.

Frame bytes arrive on a byte-wide valid/ready stream with a last marker. When a frame starts, the writer decides whether to accept it. It refuses the frame if the receiver is halted, or if the space between the current page and the boundary is smaller than a fixed worst-case frame reservation. A refused frame is still consumed from the stream but is never written. An accepted frame is written from offset 4 of the current page onward, wrapping from the limit page back to the first page. Frames that are too short are padded with zero bytes. The descriptor is then written into the first four bytes of the page. After that, the current page moves to the computed next page and a one-cycle completion pulse is raised. The host may place the current page through a load port while the writer is idle.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, s_ready, wr_en and rx_done are 0 and cur_page equals 0.
- R2: For every stored frame, the first four bytes of its page (byte address cur_page*256 + 0..3) hold, in this order, the status value 0x01, the next page number, the low byte and then the high byte of the stored length, where the stored length is the padded frame size plus 4.
- R3: Frame byte i of an accepted frame is written at byte address cur_page*256 + 4 + i, in arrival order.
- R4: A frame of fewer than 60 bytes is stored as 60 bytes, and bytes beyond the received ones are written as 0x00.
- R5: When a data address would reach limit_page*256, writing continues at first_page*256, and the limit page is never written.
- R6: The next page equals cur_page + floor((stored length + 4 + 255) / 256). If that sum is greater than or equal to limit_page, limit_page − first_page is subtracted from it.
- R7: When the descriptor has been written, cur_page takes the next-page value and rx_done is 1 for exactly one cycle, in the same cycle that cur_page changes.
- R8: Free space in bytes is (boundary − current)*256 when current < boundary, and otherwise (limit − first)*256 − (current − boundary)*256. A frame that starts while free space is below 1518 bytes is consumed with no memory write, no change of cur_page and no rx_done. A frame that starts with 1518 or more bytes free, including the case current = boundary, is stored.
- R9: A frame that starts while rx_halt is 1 is consumed with no memory write, no change of cur_page and no rx_done.
- R10: s_ready is 0 while the writer is idle and while padding or descriptor bytes are written. s_ready is 1 for every byte of a refused frame until its last byte is taken.
- R11: cur_load copies cur_load_page into cur_page only when the writer is idle. A cur_load during a frame has no effect on cur_page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_halt | input | 1 | Receiver halted; new frames are refused |
| first_page | input | 8 | First page of the ring |
| limit_page | input | 8 | Page one past the end of the ring |
| bound_page | input | 8 | Host read boundary page |
| cur_load | input | 1 | Load cur_page from cur_load_page (idle only) |
| cur_load_page | input | 8 | Value for the current page load |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Last byte of the frame |
| s_ready | output | 1 | Writer takes the byte this cycle |
| wr_en | output | 1 | Memory byte write strobe |
| wr_addr | output | 16 | Memory byte address |
| wr_data | output | 8 | Memory write byte |
| cur_page | output | 8 | Current page pointer |
| rx_done | output | 1 | One-cycle pulse when a frame is committed |

## Verification
The bench aims at the length boundaries where the page count changes. A 248-byte frame takes one page and a 249-byte frame takes two. A writer that rounds with the wrong offset puts the next frame on top of this one, or leaves a page unused. It sends a frame that straddles the limit page: a writer that compares with the wrong address writes past the ring, or loses the tail, or fails to subtract the ring size from the next page. It tests the space check on both sides of the 1518-byte reservation and with current equal to boundary. An off-by-one in this check either overwrites unread data or refuses frames into an empty ring. It also checks that short frames get zero padding and a stored length of 64, and that a pointer load issued in the middle of a frame is discarded rather than corrupting the commit.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
   typedef enum logic [2:0] {
      RW_IDLE,
      RW_DATA,
      RW_PAD,
      RW_HDR,
      RW_DROP
   } rw_state_e;

   localparam logic [7:0] RX_STATUS_GOOD = 8'h01;
   localparam int HDR_BYTES  = 4;
   localparam int TAIL_BYTES = 4;
endpackage

// File: rtl/rrw_space.sv
module rrw_space #(
   parameter int PAGE_W  = 8,
   parameter int OFF_W   = 8,
   parameter int RESERVE = 1518
) (
   input  logic [PAGE_W-1:0] cur,
   input  logic [PAGE_W-1:0] bound,
   input  logic [PAGE_W-1:0] first,
   input  logic [PAGE_W-1:0] limit,
   output logic              full
);
   localparam int SW = PAGE_W + OFF_W + 2;
   localparam logic signed [SW-1:0] RES = SW'(RESERVE);

   logic signed [SW-1:0] idx_b, bnd_b, ring_b, avail;

   assign idx_b  = $signed({2'b00, cur,   {OFF_W{1'b0}}});
   assign bnd_b  = $signed({2'b00, bound, {OFF_W{1'b0}}});
   assign ring_b = $signed({2'b00, limit, {OFF_W{1'b0}}}) -
                   $signed({2'b00, first, {OFF_W{1'b0}}});

   always_comb begin
      if (idx_b < bnd_b) avail = bnd_b - idx_b;
      else               avail = ring_b - (idx_b - bnd_b);
   end

   assign full = (avail < RES);
endmodule

// File: rtl/rrw_wrap_step.sv
module rrw_wrap_step #(
   parameter int PAGE_W = 8,
   parameter int OFF_W  = 8
) (
   input  logic [PAGE_W+OFF_W-1:0] addr,
   input  logic [PAGE_W-1:0]       first,
   input  logic [PAGE_W-1:0]       limit,
   output logic [PAGE_W+OFF_W-1:0] nxt
);
   localparam int AW = PAGE_W + OFF_W;
   logic [AW-1:0] inc;

   assign inc = addr + AW'(1);
   assign nxt = (inc == {limit, {OFF_W{1'b0}}}) ? {first, {OFF_W{1'b0}}} : inc;
endmodule

// File: rtl/rrw_next_page.sv
module rrw_next_page
   import rrw_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int OFF_W  = 8,
   parameter int LEN_W  = 16
) (
   input  logic [PAGE_W-1:0] cur,
   input  logic [PAGE_W-1:0] first,
   input  logic [PAGE_W-1:0] limit,
   input  logic [LEN_W-1:0]  frame_len,
   output logic [PAGE_W-1:0] np
);
   localparam int RW    = LEN_W + 2;
   localparam int ROUND = HDR_BYTES + TAIL_BYTES + (1 << OFF_W) - 1;

   logic [PAGE_W:0] span, sum, ring;

   assign span = (PAGE_W+1)'((RW'(frame_len) + RW'(ROUND)) >> OFF_W);
   assign sum  = {1'b0, cur} + span;
   assign ring = {1'b0, limit} - {1'b0, first};

   always_comb begin
      if (sum >= {1'b0, limit}) np = PAGE_W'(sum - ring);
      else                      np = sum[PAGE_W-1:0];
   end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
   import rrw_pkg::*;
#(
   parameter int PAGE_W    = 8,
   parameter int OFF_W     = 8,
   parameter int LEN_W     = 16,
   parameter int MIN_FRAME = 60,
   parameter int RESERVE   = 1518,
   parameter int CUR_RST   = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_halt,
   input  logic [PAGE_W-1:0]       first_page,
   input  logic [PAGE_W-1:0]       limit_page,
   input  logic [PAGE_W-1:0]       bound_page,
   input  logic                    cur_load,
   input  logic [PAGE_W-1:0]       cur_load_page,
   input  logic                    s_valid,
   input  logic [7:0]              s_data,
   input  logic                    s_last,
   output logic                    s_ready,
   output logic                    wr_en,
   output logic [PAGE_W+OFF_W-1:0] wr_addr,
   output logic [7:0]              wr_data,
   output logic [PAGE_W-1:0]       cur_page,
   output logic                    rx_done
);
   localparam int AW = PAGE_W + OFF_W;

   generate
      if (LEN_W < 12 || LEN_W > 16)
         $error("LEN_W must lie in 12..16");
      if (OFF_W < 3)
         $error("OFF_W must leave room for the descriptor");
      if (RESERVE > (1 << AW))
         $error("RESERVE exceeds the address space");
      if (MIN_FRAME < 0 || MIN_FRAME >= (1 << LEN_W))
         $error("MIN_FRAME out of range");
   endgenerate

   rw_state_e         st;
   logic [AW-1:0]     wptr, wptr_nx;
   logic [LEN_W-1:0]  cnt, cnt_inc;
   logic [1:0]        hidx;
   logic [PAGE_W-1:0] cur_q, np;
   logic              done_q, full, pad_need;
   logic [15:0]       hlen;

   rrw_space #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .RESERVE(RESERVE)) u_space (
      .cur(cur_q), .bound(bound_page), .first(first_page), .limit(limit_page),
      .full(full)
   );

   rrw_wrap_step #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_step (
      .addr(wptr), .first(first_page), .limit(limit_page), .nxt(wptr_nx)
   );

   rrw_next_page #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_np (
      .cur(cur_q), .first(first_page), .limit(limit_page), .frame_len(cnt),
      .np(np)
   );

   assign cnt_inc = cnt + LEN_W'(1);
   assign hlen    = 16'(cnt) + 16'(HDR_BYTES);

   generate
      if (MIN_FRAME > 1) begin : g_pad
         assign pad_need = (cnt_inc < LEN_W'(MIN_FRAME));
      end else begin : g_nopad
         assign pad_need = 1'b0;
      end
   endgenerate

   assign s_ready  = (st == RW_DATA) || (st == RW_DROP);
   assign cur_page = cur_q;
   assign rx_done  = done_q;

   always_comb begin
      wr_en   = 1'b0;
      wr_addr = wptr;
      wr_data = 8'h00;
      unique case (st)
         RW_DATA: begin
            wr_en   = s_valid;
            wr_data = s_data;
         end
         RW_PAD: begin
            wr_en   = 1'b1;
         end
         RW_HDR: begin
            wr_en   = 1'b1;
            wr_addr = {cur_q, OFF_W'(hidx)};
            unique case (hidx)
               2'd0:    wr_data = RX_STATUS_GOOD;
               2'd1:    wr_data = 8'(np);
               2'd2:    wr_data = hlen[7:0];
               default: wr_data = hlen[15:8];
            endcase
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= RW_IDLE;
         cur_q  <= PAGE_W'(CUR_RST);
         wptr   <= '0;
         cnt    <= '0;
         hidx   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            RW_IDLE: begin
               if (cur_load) begin
                  cur_q <= cur_load_page;
               end else if (s_valid) begin
                  if (rx_halt || full) begin
                     st <= RW_DROP;
                  end else begin
                     st   <= RW_DATA;
                     wptr <= {cur_q, OFF_W'(HDR_BYTES)};
                     cnt  <= '0;
                  end
               end
            end
            RW_DATA: begin
               if (s_valid) begin
                  cnt  <= cnt_inc;
                  wptr <= wptr_nx;
                  if (s_last) begin
                     st   <= pad_need ? RW_PAD : RW_HDR;
                     hidx <= '0;
                  end
               end
            end
            RW_PAD: begin
               cnt  <= cnt_inc;
               wptr <= wptr_nx;
               if (!pad_need) st <= RW_HDR;
            end
            RW_HDR: begin
               hidx <= hidx + 2'd1;
               if (hidx == 2'd3) begin
                  cur_q  <= np;
                  done_q <= 1'b1;
                  st     <= RW_IDLE;
               end
            end
            RW_DROP: begin
               if (s_valid && s_last) st <= RW_IDLE;
            end
            default: st <= RW_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk
   import rrw_pkg::*;
#(
   parameter int PAGE_W = 8,
   parameter int OFF_W  = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input rw_state_e               st,
   input logic                    s_valid,
   input logic                    rx_halt,
   input logic                    cur_load,
   input logic                    wr_en,
   input logic [PAGE_W+OFF_W-1:0] wr_addr,
   input logic [PAGE_W-1:0]       limit_page,
   input logic [PAGE_W-1:0]       cur_page,
   input logic                    rx_done
);
   // R5
   limit_page_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr[PAGE_W+OFF_W-1:OFF_W] != limit_page));

   // R7
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R11
   cur_moves_legally_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_page) |-> (rx_done || $past(cur_load && st == RW_IDLE)));

   // R9
   halted_frame_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RW_IDLE && s_valid && rx_halt && !cur_load) |=> !wr_en);
endmodule

bind rx_ring_writer rx_ring_writer_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .s_valid(s_valid), .rx_halt(rx_halt),
   .cur_load(cur_load), .wr_en(wr_en), .wr_addr(wr_addr),
   .limit_page(limit_page), .cur_page(cur_page), .rx_done(rx_done)
);

// File: tb/rx_ring_writer_tb.sv
`timescale 1ns/1ps
module rx_ring_writer_tb;
   localparam int FIRST = 'h40;
   localparam int LIMIT = 'h80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_halt = 1'b0;
   logic [7:0] first_page = 8'(FIRST);
   logic [7:0] limit_page = 8'(LIMIT);
   logic [7:0] bound_page = 8'(FIRST);
   logic cur_load = 1'b0;
   logic [7:0] cur_load_page = 8'h00;
   logic s_valid = 1'b0;
   logic [7:0] s_data = 8'h00;
   logic s_last = 1'b0;
   logic s_ready, wr_en, rx_done;
   logic [15:0] wr_addr;
   logic [7:0] wr_data, cur_page;

   int total = 0, bad = 0, wcount = 0, dcount = 0, ready_viol = 0;
   logic [7:0] mem [int];

   always #2.5 clk = ~clk;

   rx_ring_writer u_dut (
      .clk(clk), .rst_n(rst_n), .rx_halt(rx_halt), .first_page(first_page),
      .limit_page(limit_page), .bound_page(bound_page), .cur_load(cur_load),
      .cur_load_page(cur_load_page), .s_valid(s_valid), .s_data(s_data),
      .s_last(s_last), .s_ready(s_ready), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cur_page(cur_page), .rx_done(rx_done)
   );

   always @(posedge clk) begin
      if (rst_n && wr_en) begin
         mem[int'(wr_addr)] = wr_data;
         wcount++;
      end
      if (rst_n && rx_done) dcount++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int rd(input int a);
      return mem.exists(a) ? int'(mem[a]) : -1;
   endfunction

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((seed + i * 7) & 'hff);
   endfunction

   function automatic int exp_addr(input int c, input int i);
      int a = c * 256 + 4 + i;
      if (a >= LIMIT * 256) a -= (LIMIT - FIRST) * 256;
      return a;
   endfunction

   function automatic int exp_np(input int c, input int len);
      int p = (len < 60) ? 60 : len;
      int n = c + (p + 4 + 4 + 255) / 256;
      if (n >= LIMIT) n -= (LIMIT - FIRST);
      return n;
   endfunction

   task automatic load_cur(input int v);
      cur_load = 1'b1; cur_load_page = 8'(v);
      @(negedge clk);
      cur_load = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_frame(input int len, input int seed);
      for (int i = 0; i < len; i++) begin
         s_valid = 1'b1; s_data = pat(seed, i); s_last = (i == len - 1);
         while (!s_ready) @(negedge clk);
         @(negedge clk);
      end
      s_valid = 1'b0; s_last = 1'b0;
   endtask

   task automatic wait_done(output bit got);
      got = 1'b0;
      for (int n = 0; n < 300; n++) begin
         if (rx_done) begin got = 1'b1; break; end
         if (s_ready) ready_viol++;
         @(negedge clk);
      end
   endtask

   task automatic store_and_verify(input int c, input int len, input int seed, input string tag);
      int p = (len < 60) ? 60 : len;
      int t = p + 4;
      int n = exp_np(c, len);
      int d0 = dcount;
      int dmis = 0, pmis = 0, v0;
      bit got;
      v0 = ready_viol;
      send_frame(len, seed);
      wait_done(got);
      chk(got, {tag, " R7 done pulse"}, int'(got), 1);
      chk(ready_viol == v0, {tag, " R10 ready low in pad/header"}, ready_viol - v0, 0);
      chk(cur_page == 8'(n), {tag, " R7 R6 cur_page"}, cur_page, n);
      @(negedge clk);
      chk(dcount == d0 + 1 && !rx_done, {tag, " R7 single pulse"}, dcount - d0, 1);
      chk(rd(c * 256) == 1, {tag, " R2 status"}, rd(c * 256), 1);
      chk(rd(c * 256 + 1) == n, {tag, " R2 R6 next page"}, rd(c * 256 + 1), n);
      chk(rd(c * 256 + 2) == (t & 'hff), {tag, " R2 len low"}, rd(c * 256 + 2), t & 'hff);
      chk(rd(c * 256 + 3) == (t >> 8), {tag, " R2 len high"}, rd(c * 256 + 3), t >> 8);
      for (int i = 0; i < len; i++)
         if (rd(exp_addr(c, i)) != int'(pat(seed, i))) dmis++;
      chk(dmis == 0, {tag, " R3 data bytes"}, dmis, 0);
      for (int i = len; i < p; i++)
         if (rd(exp_addr(c, i)) != 0) pmis++;
      chk(pmis == 0, {tag, " R4 pad bytes"}, pmis, 0);
   endtask

   task automatic expect_drop(input int len, input string tag);
      int w0 = wcount, d0 = dcount, c0 = int'(cur_page), rdy = 0;
      for (int i = 0; i < len; i++) begin
         s_valid = 1'b1; s_data = pat(9, i); s_last = (i == len - 1);
         while (!s_ready) @(negedge clk);
         rdy++;
         @(negedge clk);
      end
      s_valid = 1'b0; s_last = 1'b0;
      repeat (10) @(negedge clk);
      chk(rdy == len && !s_ready, {tag, " R10 drop consumed"}, rdy, len);
      chk(wcount == w0, {tag, " no write"}, wcount - w0, 0);
      chk(dcount == d0, {tag, " no done"}, dcount - d0, 0);
      chk(int'(cur_page) == c0, {tag, " cur kept"}, cur_page, c0);
   endtask

   task automatic t_reset;
      chk(!s_ready && !wr_en && !rx_done && cur_page == 8'h00, "R1 reset outputs",
          {s_ready, wr_en, rx_done}, 0);
      chk(cur_page == 8'h00, "R1 reset cur_page", cur_page, 0);
   endtask

   task automatic t_normal;
      load_cur('h46);
      chk(cur_page == 8'h46, "R11 idle load", cur_page, 'h46);
      store_and_verify('h46, 100, 3, "normal");
   endtask

   task automatic t_short;
      for (int i = 20; i < 60; i++) mem[exp_addr('h47, i)] = 8'hEE;
      store_and_verify('h47, 20, 11, "short R4");
   endtask

   task automatic t_page_edges;
      store_and_verify('h48, 248, 21, "len248 R6");
      store_and_verify('h49, 249, 33, "len249 R6");
   endtask

   task automatic t_wrap;
      bound_page = 8'h50;
      load_cur('h7F);
      store_and_verify('h7F, 300, 5, "wrap R5");
      chk(!mem.exists(LIMIT * 256), "R5 limit page untouched", rd(LIMIT * 256), -1);
   endtask

   task automatic t_full;
      load_cur('h4A);
      bound_page = 8'h4F;
      expect_drop(80, "R8 full");
      bound_page = 8'h50;
      store_and_verify('h4A, 100, 17, "R8 just fits");
      bound_page = 8'h4B;
      store_and_verify('h4B, 60, 23, "R8 cur eq bound");
   endtask

   task automatic t_halt;
      rx_halt = 1'b1;
      expect_drop(50, "R9 halted");
      rx_halt = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_load_busy;
      fork
         store_and_verify('h4C, 100, 41, "R11 busy load");
         begin
            repeat (20) @(negedge clk);
            cur_load = 1'b1; cur_load_page = 8'h55;
            @(negedge clk);
            cur_load = 1'b0;
         end
      join
      chk(cur_page == 8'h4D, "R11 load ignored", cur_page, 'h4D);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_normal();
      t_short();
      t_page_edges();
      t_wrap();
      t_full();
      t_halt();
      t_load_busy();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule